// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen User Registers

This block keeps a calendar clock in packed BCD: seconds, minutes, hours (24-hour), day of week, date, month, year and century. A single-cycle one-second pulse drives a carry chain of counters that knows the length of each month, the leap-year rule across centuries, and the rollover from century 99 year 99 back to 0000. Software does not see the counters directly. It sees a second, user-visible copy that is reached through a 16-byte register window at the very top of the address space.

Two flag bits decide how the copy relates to the counters. The freeze bit holds the copy still while the counters keep running, so a multi-byte read cannot tear. Clearing the freeze bit brings the copy up to date in one step. The write-enable bit opens the copy for a new base time. Clearing it moves the whole copy into the counters, and counting then continues from the new time. When neither bit is set, the copy follows the counters on every tick. Nibbles written with values that are not BCD are kept as written and count upward until they wrap.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the flags read 0x00 and the clock reads century 0x20, year 0x00, month 0x01, date 0x01, day of week 0x1, and 00:00:00.
- R2: The block responds only when every address bit above bit 3 is 1. Any other address reads 0x00, and writes to it change nothing.
- R3: Register layout by offset: 0x0 flags (bit 0 freeze, bit 1 write-enable), 0x8 century, 0x9 year, 0xA month, 0xB date, 0xC day of week (bits 3:0 only), 0xD hours, 0xE minutes, 0xF seconds. Offsets 0x1 to 0x7, flag bits 7:2 and day-of-week bits 7:4 read 0. Read data is combinational and is 0x00 whenever no read is presented.
- R4: With both flags clear, each tick advances seconds by one, and the user registers show the new count in the cycle after the tick.
- R5: Seconds and minutes roll from 0x59 to 0x00. Hours roll from 0x23 to 0x00. Each roll carries into the next field. A day carry advances the day of week, with 7 going to 1.
- R6: The date rolls to 0x01 after 0x28 or 0x29 in month 0x02, after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in every other month. The 29th is used when the four-digit year (century times 100 plus year) is divisible by 4 and is not a century year that is not divisible by 400.
- R7: Month 0x12 rolls to 0x01 and carries into the year. Year 0x99 rolls to 0x00 and carries into the century. Century 0x99 rolls to 0x00.
- R8: While the freeze bit is 1, the user registers hold still and the counters keep counting. Writing 0 to the freeze bit makes all user registers show the counters at once.
- R9: A write to a time register while the write-enable bit is 0 is ignored.
- R10: While write-enable is 1, writes to time registers are stored. Writing 0 to write-enable loads them into the counters, and counting resumes from them. A tick in that same cycle is dropped.
- R11: A field wraps to its minimum only when it equals its maximum. Otherwise a low nibble of 9 or 0xF becomes 0 and increments the high nibble (0xF wraps to 0x0). Any other low nibble, including 0xA to 0xE, increments by one.
- R12: A day-of-week value outside 1 to 7 increments as a 4-bit value on each day carry, wrapping from 0xF to 0x0. The value 7 always goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_en | input | 1 | Register access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 unless a read hits the window |

## Verification
The bench drives the clock across the boundaries where a slip would show:
- **Year ending:** the last second of a year. A wrong carry order would stop the rollover short of the century.
- **February in a common year:** a missing leap test would produce 02-29.
- **February in century years:** one year divisible by 400 and one that is not. Taking the leap rule from the two-digit year alone would get one of them wrong.
- **Month lengths:** the end of a 30-day month. A design that reads the month after it has been advanced would pick the wrong length.

It freezes the copy and ticks on. A copy that kept following the counters, or that failed to catch up when the freeze ends, differs from the model at once.

It loads a new base time, including a tick in the very cycle write-enable clears. It also writes time registers while write-enable is 0, and to addresses just outside the window. A design that counted on the tick would show the difference, and so would one that accepted the stray writes.

Malformed nibbles (0x3C seconds, 0xF9 seconds, 0x1A hours, day of week 0 and 9) expose any design that clamps, wraps early or carries on a bad digit.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int NF     = 7;   // chained two-digit fields

  // chain order (carry flows upward)
  localparam int FI_SEC  = 0;
  localparam int FI_MIN  = 1;
  localparam int FI_HR   = 2;
  localparam int FI_DATE = 3;
  localparam int FI_MON  = 4;
  localparam int FI_YR   = 5;
  localparam int FI_CEN  = 6;

  localparam logic [3:0] OFF_FLAGS = 4'h0;
  localparam logic [3:0] OFF_CEN   = 4'h8;
  localparam logic [3:0] OFF_YR    = 4'h9;
  localparam logic [3:0] OFF_MON   = 4'hA;
  localparam logic [3:0] OFF_DATE  = 4'hB;
  localparam logic [3:0] OFF_DOW   = 4'hC;
  localparam logic [3:0] OFF_HR    = 4'hD;
  localparam logic [3:0] OFF_MIN   = 4'hE;
  localparam logic [3:0] OFF_SEC   = 4'hF;

  localparam int FLAG_FRZ = 0;
  localparam int FLAG_WEN = 1;

  typedef struct packed {
    logic [BYTE_W-1:0] cen;
    logic [BYTE_W-1:0] yr;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] date;
    logic [NIB_W-1:0]  dow;
    logic [BYTE_W-1:0] hr;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] sec;
  } bcd_time_t;

  localparam bcd_time_t TIME_RST = '{cen: 8'h20, yr: 8'h00, mon: 8'h01,
                                     date: 8'h01, dow: 4'h1, hr: 8'h00,
                                     min: 8'h00, sec: 8'h00};

  function automatic logic [BYTE_W-1:0] field_lo(input int idx);
    return (idx == FI_DATE || idx == FI_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [BYTE_W-1:0] field_hi(input int idx);
    case (idx)
      FI_SEC, FI_MIN: return 8'h59;
      FI_HR:          return 8'h23;
      FI_DATE:        return 8'h31;
      FI_MON:         return 8'h12;
      default:        return 8'h99;
    endcase
  endfunction
endpackage

// File: rtl/bcdclk_field.sv
module bcdclk_field
  import bcdclk_pkg::*;
(
  input  logic              en,
  input  logic [BYTE_W-1:0] val,
  input  logic [BYTE_W-1:0] lo_lim,
  input  logic [BYTE_W-1:0] hi_lim,
  output logic [BYTE_W-1:0] nxt,
  output logic              carry
);
  logic [NIB_W-1:0] lo_nib;
  logic [NIB_W-1:0] hi_nib;

  assign lo_nib = val[NIB_W-1:0];
  assign hi_nib = val[BYTE_W-1:NIB_W];

  always_comb begin
    nxt   = val;
    carry = 1'b0;
    if (en) begin
      if (val == hi_lim) begin
        nxt   = lo_lim;
        carry = 1'b1;
      end else if (lo_nib == 4'h9 || lo_nib == 4'hF) begin
        nxt = {hi_nib + 4'd1, 4'h0};
      end else begin
        nxt = {hi_nib, lo_nib + 4'd1};
      end
    end
  end
endmodule

// File: rtl/bcdclk_month_len.sv
module bcdclk_month_len
  import bcdclk_pkg::*;
(
  input  logic [BYTE_W-1:0] mon,
  input  logic [BYTE_W-1:0] yr,
  input  logic [BYTE_W-1:0] cen,
  output logic [BYTE_W-1:0] last_day
);
  logic [1:0] yr_m4;
  logic [1:0] cen_m4;
  logic       leap;
  logic       unused_cen;

  // value mod 4 of a BCD byte: (2*tens + units) mod 4
  assign yr_m4  = yr[1:0]  + {yr[4], 1'b0};
  assign cen_m4 = cen[1:0] + {cen[4], 1'b0};
  assign leap   = (yr == 8'h00) ? (cen_m4 == 2'd0) : (yr_m4 == 2'd0);
  assign unused_cen = ^{cen[7:5], cen[3:2]};

  always_comb begin
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcdclk_chain.sv
module bcdclk_chain
  import bcdclk_pkg::*;
(
  input  bcd_time_t cur,
  input  logic      tick,
  output bcd_time_t nxt
);
  logic [BYTE_W-1:0] f_cur [NF];
  logic [BYTE_W-1:0] f_nxt [NF];
  logic [NF:0]       f_en;
  logic [BYTE_W-1:0] month_last;
  logic              unused_wrap;

  assign f_cur[FI_SEC]  = cur.sec;
  assign f_cur[FI_MIN]  = cur.min;
  assign f_cur[FI_HR]   = cur.hr;
  assign f_cur[FI_DATE] = cur.date;
  assign f_cur[FI_MON]  = cur.mon;
  assign f_cur[FI_YR]   = cur.yr;
  assign f_cur[FI_CEN]  = cur.cen;
  assign f_en[0]        = tick;
  assign unused_wrap    = f_en[NF];

  // length of the current (not yet advanced) month
  bcdclk_month_len u_len (
    .mon      (cur.mon),
    .yr       (cur.yr),
    .cen      (cur.cen),
    .last_day (month_last)
  );

  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam logic [BYTE_W-1:0] LO = field_lo(i);
    localparam logic [BYTE_W-1:0] HI = field_hi(i);
    logic [BYTE_W-1:0] hi_lim;
    if (i == FI_DATE) begin : g_dyn
      assign hi_lim = month_last;
    end else begin : g_fix
      assign hi_lim = HI;
    end
    bcdclk_field u_fld (
      .en     (f_en[i]),
      .val    (f_cur[i]),
      .lo_lim (LO),
      .hi_lim (hi_lim),
      .nxt    (f_nxt[i]),
      .carry  (f_en[i+1])
    );
  end

  always_comb begin
    nxt      = cur;
    nxt.sec  = f_nxt[FI_SEC];
    nxt.min  = f_nxt[FI_MIN];
    nxt.hr   = f_nxt[FI_HR];
    nxt.date = f_nxt[FI_DATE];
    nxt.mon  = f_nxt[FI_MON];
    nxt.yr   = f_nxt[FI_YR];
    nxt.cen  = f_nxt[FI_CEN];
    if (f_en[FI_HR+1]) begin
      nxt.dow = (cur.dow == 4'h7) ? 4'h1 : cur.dow + 4'h1;
    end
  end
endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
  import bcdclk_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata
);
  localparam int OFF_W = 4;

  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic              hit;
  logic [OFF_W-1:0]  off;
  logic              acc_wr;
  logic              flags_wr;
  logic              time_wr;
  logic              frz_q, frz_d;
  logic              wen_q, wen_d;
  logic              wen_fall;
  logic              cnt_en;
  bcd_time_t         cnt_q, cnt_d, chain_nxt;
  bcd_time_t         ureg_q, ureg_d, ureg_w;
  logic [BYTE_W-1:0] rd_val;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign hit      = &bus_addr[AW-1:OFF_W];
  assign off      = bus_addr[OFF_W-1:0];
  assign acc_wr   = bus_en && bus_we && hit;
  assign flags_wr = acc_wr && (off == OFF_FLAGS);
  assign time_wr  = acc_wr && off[OFF_W-1] && wen_q;

  bcdclk_chain u_chain (
    .cur  (cnt_q),
    .tick (tick_1hz),
    .nxt  (chain_nxt)
  );

  // next state
  always_comb begin
    frz_d    = flags_wr ? bus_wdata[FLAG_FRZ] : frz_q;
    wen_d    = flags_wr ? bus_wdata[FLAG_WEN] : wen_q;
    wen_fall = wen_q && !wen_d;
    cnt_en   = wen_fall || tick_1hz;
    cnt_d    = wen_fall ? ureg_q : chain_nxt;
  end

  always_comb begin
    ureg_w = ureg_q;
    if (time_wr) begin
      case (off)
        OFF_CEN:  ureg_w.cen  = bus_wdata;
        OFF_YR:   ureg_w.yr   = bus_wdata;
        OFF_MON:  ureg_w.mon  = bus_wdata;
        OFF_DATE: ureg_w.date = bus_wdata;
        OFF_DOW:  ureg_w.dow  = bus_wdata[NIB_W-1:0];
        OFF_HR:   ureg_w.hr   = bus_wdata;
        OFF_MIN:  ureg_w.min  = bus_wdata;
        OFF_SEC:  ureg_w.sec  = bus_wdata;
        default: ;
      endcase
    end
    ureg_d = (!frz_d && !wen_d) ? cnt_d : ureg_w;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      frz_q <= 1'b0;
      wen_q <= 1'b0;
    end else if (flags_wr) begin
      frz_q <= frz_d;
      wen_q <= wen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    cnt_q <= TIME_RST;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ureg_q <= TIME_RST;
    else          ureg_q <= ureg_d;
  end

  // read path
  always_comb begin
    rd_val = '0;
    case (off)
      OFF_FLAGS: begin
        rd_val[FLAG_FRZ] = frz_q;
        rd_val[FLAG_WEN] = wen_q;
      end
      OFF_CEN:  rd_val = ureg_q.cen;
      OFF_YR:   rd_val = ureg_q.yr;
      OFF_MON:  rd_val = ureg_q.mon;
      OFF_DATE: rd_val = ureg_q.date;
      OFF_DOW:  rd_val = {4'h0, ureg_q.dow};
      OFF_HR:   rd_val = ureg_q.hr;
      OFF_MIN:  rd_val = ureg_q.min;
      OFF_SEC:  rd_val = ureg_q.sec;
      default: ;
    endcase
  end

  assign bus_rdata = (bus_en && !bus_we && hit) ? rd_val : '0;
endmodule

// File: rtl/bcd_cal_clock_chk.sv
module bcd_cal_clock_chk
  import bcdclk_pkg::*;
#(
  parameter int AW = 15
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              tick_1hz,
  input logic              bus_en,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              frz_q,
  input logic              wen_q,
  input bcd_time_t         cnt_q,
  input bcd_time_t         ureg_q
);
  logic in_win;
  assign in_win = &bus_addr[AW-1:4];

  assert_free_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!frz_q && !wen_q) |-> (ureg_q == cnt_q));

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!tick_1hz && !wen_q) |=> $stable(cnt_q));

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frz_q && !(bus_en && bus_we && in_win)) |=> $stable(ureg_q));

  assert_load_on_clear_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(wen_q) |-> (cnt_q == $past(ureg_q)));

  assert_outside_zero_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_en && !in_win) |-> (bus_rdata == '0));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_en && !bus_we && in_win && !bus_addr[3] && bus_addr[2:0] != 3'd0)
      |-> (bus_rdata == '0));
endmodule

bind bcd_cal_clock bcd_cal_clock_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .tick_1hz  (tick_1hz),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .frz_q     (frz_q),
  .wen_q     (wen_q),
  .cnt_q     (cnt_q),
  .ureg_q    (ureg_q)
);

// File: tb/bcd_cal_clock_test.sv
module bcd_cal_clock_test;
  localparam int CLK_NS = 10;
  localparam int AW     = 15;
  localparam logic [AW-1:0] BASE = 15'h7FF0;

  logic          clk;
  logic          rst_n;
  logic          tick_1hz;
  logic          bus_en;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata;

  int    total;
  int    bad;
  string tag;
  bit    finished;
  int    rot;

  // reference state: index = offset - 8 (cen, yr, mon, date, dow, hr, min, sec)
  int mc [8];
  int mu [8];
  bit mr;
  bit mw;

  bcd_cal_clock #(.AW(AW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  function automatic int days_in(input int mon, input int yr, input int cen);
    int m, y;
    bit leap;
    m = (mon >> 4) * 10 + (mon & 15);
    y = ((cen >> 4) * 10 + (cen & 15)) * 100 + (yr >> 4) * 10 + (yr & 15);
    leap = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    if (m == 2) return leap ? 'h29 : 'h28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 'h30;
    return 'h31;
  endfunction

  function automatic int bump(input int v, input int lo, input int hi, output bit cy);
    int ln, hn;
    cy = 1'b0;
    if (v == hi) begin
      cy = 1'b1;
      return lo;
    end
    ln = v & 15;
    hn = v >> 4;
    if (ln == 9 || ln == 15) return ((hn + 1) & 15) << 4;
    return (hn << 4) | (ln + 1);
  endfunction

  task automatic model_tick();
    bit c;
    int lim;
    mc[7] = bump(mc[7], 0, 'h59, c);
    if (c) begin
      mc[6] = bump(mc[6], 0, 'h59, c);
      if (c) begin
        mc[5] = bump(mc[5], 0, 'h23, c);
        if (c) begin
          mc[4] = (mc[4] == 7) ? 1 : ((mc[4] + 1) & 15);
          lim = days_in(mc[2], mc[1], mc[0]);
          mc[3] = bump(mc[3], 1, lim, c);
          if (c) begin
            mc[2] = bump(mc[2], 1, 'h12, c);
            if (c) begin
              mc[1] = bump(mc[1], 0, 'h99, c);
              if (c) mc[0] = bump(mc[0], 0, 'h99, c);
            end
          end
        end
      end
    end
  endtask

  function automatic int model_rd(input int off);
    if (off == 0) return (int'(mw) << 1) | int'(mr);
    if (off >= 8) return mu[off-8];
    return 0;
  endfunction

  task automatic check(input int act, input int exp, input int off);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s off=%h actual=%h expected=%h", tag, off, act, exp);
    end
  endtask

  task automatic cyc(input bit en, input bit we, input logic [AW-1:0] a,
                     input logic [7:0] d, input bit tk);
    int  exp, off, nr, nw;
    bit  hitm;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; tick_1hz = tk;
    #1;
    off  = int'(a[3:0]);
    hitm = en && ((a >> 4) == (BASE >> 4));
    exp  = (hitm && !we) ? model_rd(off) : 0;
    check(int'(bus_rdata), exp, off);
    @(posedge clk);
    nr = mr; nw = mw;
    if (hitm && we && off == 0) begin
      nr = d[0];
      nw = d[1];
    end
    if (mw && nw == 0) begin
      for (int k = 0; k < 8; k++) mc[k] = mu[k];
    end else if (tk) begin
      model_tick();
    end
    if (hitm && we && off >= 8 && mw) mu[off-8] = (off == 12) ? int'(d & 8'h0F) : int'(d);
    if (nr == 0 && nw == 0) begin
      for (int k = 0; k < 8; k++) mu[k] = mc[k];
    end
    mr = nr[0];
    mw = nw[0];
  endtask

  task automatic rd(input int off);
    cyc(1'b1, 1'b0, BASE + AW'(off), 8'h00, 1'b0);
  endtask

  task automatic wr(input int off, input int d);
    cyc(1'b1, 1'b1, BASE + AW'(off), 8'(d), 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      cyc(1'b1, 1'b0, BASE + AW'(8 + rot), 8'h00, 1'b1);
      rot = (rot + 1) % 8;
    end
  endtask

  task automatic read_all();
    for (int k = 0; k < 16; k++) rd(k);
  endtask

  task automatic set_time(input int c, input int y, input int mo, input int dt,
                          input int dw, input int h, input int mi, input int s);
    wr(0, 2);
    wr(8, c); wr(9, y); wr(10, mo); wr(11, dt);
    wr(12, dw); wr(13, h); wr(14, mi); wr(15, s);
    wr(0, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    tag = "watchdog";
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    total = 0; bad = 0; finished = 1'b0; rot = 0;
    rst_n = 1'b0; tick_1hz = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    mc = '{'h20, 'h00, 'h01, 'h01, 'h1, 'h00, 'h00, 'h00};
    mu = mc;
    mr = 1'b0; mw = 1'b0;
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, '0, 8'h00, 1'b0);

    tag = "R1"; read_all();
    tag = "R3"; for (int k = 1; k < 8; k++) rd(k);

    tag = "R2";
    cyc(1'b1, 1'b0, 15'h3FF8, 8'h00, 1'b0);
    cyc(1'b1, 1'b1, 15'h0FF0, 8'h03, 1'b0);
    rd(0);

    tag = "R4"; ticks(5); read_all();

    tag = "R9"; wr(15, 'h42); wr(9, 'h77); rd(15); rd(9);

    tag = "R10";
    wr(0, 2); wr(15, 'h30); wr(14, 'h15);
    cyc(1'b1, 1'b1, 15'h7EFF, 8'h55, 1'b0);
    ticks(2); rd(0); rd(15); rd(14); rd(15 - 8 + 8);
    wr(0, 0); rd(15); ticks(3);
    wr(0, 2); wr(15, 'h10);
    cyc(1'b1, 1'b1, BASE, 8'h00, 1'b1);
    rd(15); ticks(1);

    tag = "R3";
    wr(0, 2); wr(12, 'hF5); rd(12); rd(0); wr(0, 0); rd(12); rd(0);

    tag = "R5";
    set_time('h20, 'h23, 'h02, 'h14, 7, 'h23, 'h59, 'h58);
    ticks(3); read_all();

    tag = "R6";
    set_time('h20, 'h23, 'h02, 'h28, 2, 'h23, 'h59, 'h59); ticks(1); read_all();
    set_time('h20, 'h24, 'h02, 'h28, 2, 'h23, 'h59, 'h59); ticks(1); read_all();
    ticks(1); set_time('h20, 'h24, 'h02, 'h29, 3, 'h23, 'h59, 'h59); ticks(1); read_all();
    set_time('h21, 'h00, 'h02, 'h28, 2, 'h23, 'h59, 'h59); ticks(1); read_all();
    set_time('h20, 'h00, 'h02, 'h28, 2, 'h23, 'h59, 'h59); ticks(1); read_all();
    set_time('h20, 'h23, 'h04, 'h30, 2, 'h23, 'h59, 'h59); ticks(1); read_all();
    set_time('h20, 'h23, 'h11, 'h30, 2, 'h23, 'h59, 'h59); ticks(1); read_all();

    tag = "R7";
    set_time('h20, 'h99, 'h12, 'h31, 5, 'h23, 'h59, 'h59); ticks(1); read_all();
    set_time('h99, 'h99, 'h12, 'h31, 5, 'h23, 'h59, 'h59); ticks(2); read_all();

    tag = "R8";
    set_time('h20, 'h30, 'h06, 'h15, 4, 'h10, 'h20, 'h55);
    wr(0, 1); ticks(8); read_all();
    wr(0, 0); read_all(); ticks(2); rd(15);

    tag = "R11";
    set_time('h20, 'h30, 'h06, 'h15, 4, 'h10, 'h20, 'h3C); ticks(5); read_all();
    set_time('h20, 'h30, 'h06, 'h15, 4, 'h10, 'h20, 'hF9); ticks(1); read_all();
    set_time('h20, 'h30, 'h06, 'h15, 4, 'h1A, 'h59, 'h59); ticks(1); read_all();

    tag = "R12";
    set_time('h20, 'h30, 'h06, 'h15, 0, 'h23, 'h59, 'h59); ticks(1); rd(12); rd(11);
    set_time('h20, 'h30, 'h06, 'h15, 9, 'h23, 'h59, 'h59); ticks(1); rd(12); rd(11);
    set_time('h20, 'h30, 'h06, 'h15, 'hF, 'h23, 'h59, 'h59); ticks(1); rd(12);

    summary();
  end
endmodule